// File: doc/BRIEF.md
# Keyed system control register bank

A bank of 32-bit system status and control registers behind a plain register bus: write strobe, read strobe, word address and write data in, registered read data out. It carries a fixed identity word, an LED register, two configuration data words, a volatile and a non-volatile flag word with separate set and clear addresses, a multi-card status word, a display control word and a tick counter. A reset-control register can only be written after software has loaded a sixteen-bit unlock key. A write to that register can ask for a system reset through a one-cycle pulse.

The board type is bits 27:16 of the identity parameter. It is fixed when the block is elaborated. It selects which display bits are writable, the display reset value, whether a 2-bit display mux output exists, where the write-protect input lands in the card status word, and whether reset control and the display register are present at all. Locations that exist but have no function here read as zero. Holes in the map read as zero and raise a one-cycle bad-access flag.

Top module: `sysreg_bank`

## Requirements
- R1: A write of exactly 0x0000A05F to word 0x08 (byte 0x20) stores 0xA05F in the lock register. Any other 32-bit value stores its low 16 bits with bit 15 cleared. The register reads back zero-extended.
- R2: A write to reset control (word 0x10, byte 0x40) updates it only while the lock register holds 0xA05F. If that accepted write has bit 8 set, reset_req_o is high for exactly the cycle after the write.
- R3: A write to word 0x0C ORs the data into the flag word. A write to word 0x0D clears the flag bits that are one in the data. Word 0x0C reads the flag word and word 0x0D reads zero.
- R4: Words 0x0E and 0x0F do the same for the non-volatile flags, and word 0x0F reads zero. The non-volatile flags are cleared only by por_n and keep their value through rst_n.
- R5: rst_n clears the LED, lock, both config data, flag and reset-control registers, the tick counter and disp_mux_o. The display register returns to 0x00001F00 on every board type except 0x190.
- R6: On board type 0x190 the reset-control and display words read zero, ignore writes and never raise reset_req_o.
- R7: On board types 0x100 and 0x140, display word 0x14 (byte 0x50) keeps bits 13:8 on a write and takes all other bits from the data. On type 0x100 only, disp_mux_o takes written bits 1:0 in the cycle after the write; elsewhere it stays 0.
- R8: On board types 0x178 and 0x182 a display write keeps bit 7 and takes every other bit from the data. On any type not named in R6 to R8, the display word keeps its reset value.
- R9: Word 0x12 (card status) reads card_present_i in bit 0. write_prot_i appears in bit 2 for board types 0x100 and 0x140 and in bit 1 otherwise. All other bits read zero and writes are ignored.
- R10: Word 0x00 reads ID_WORD, word 0x11 reads 1, word 0x21 reads PROC_WORD and word 0x22 reads 0xFF000000. Word 0x17 reads a counter that advances by one in each cycle with tick_en_i high.
- R11: rdata_o shows the addressed word in the cycle after rd_en_i and is zero in any cycle that does not follow a read.
- R12: Mapped words are 0x00 to 0x1D, 0x20 to 0x27 and 0x30 to 0x34. Any other word reads zero and ignores writes. bad_access_o is high for the cycle after a read or write to such a word, and low after any other access.
- R13: LED (word 0x02) and config data (words 0x0A, 0x0B) are full 32-bit read/write registers. The other mapped words not named in R1 to R12 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset for the non-volatile flags, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| card_present_i | input | 1 | Card detect level |
| write_prot_i | input | 1 | Card write-protect level |
| tick_en_i | input | 1 | Tick counter enable strobe |
| rdata_o | output | 32 | Registered read data |
| reset_req_o | output | 1 | One-cycle system reset request |
| disp_mux_o | output | 2 | Display format mux control |
| bad_access_o | output | 1 | One-cycle flag for an access to an unmapped word |

## Verification
The bench builds three copies on one shared bus, with board types 0x100, 0x178 and 0x190. All three use the default 6-bit word address. Between them they cover the muxed display variant, the bit-7 variant, the absent variant and both write-protect bit positions. Because the address space is only 64 words, every word is read after reset and after three full write sweeps with different data patterns. That checks every hole, every read-zero location and every flag set/clear interplay against an arithmetic model. Directed sequences then cover the lock key and its near misses, reset-request pulses, survival of the non-volatile flags through bus reset, all four card input combinations and a counted burst of tick strobes.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

   localparam logic [31:0] UNLOCK_KEY = 32'h0000_A05F;

   // word indices (byte offset / 4)
   localparam logic [31:0] W_IDENT  = 32'h00;
   localparam logic [31:0] W_LED    = 32'h02;
   localparam logic [31:0] W_LOCK   = 32'h08;
   localparam logic [31:0] W_CFG1   = 32'h0A;
   localparam logic [31:0] W_CFG2   = 32'h0B;
   localparam logic [31:0] W_FSET   = 32'h0C;
   localparam logic [31:0] W_FCLR   = 32'h0D;
   localparam logic [31:0] W_NVSET  = 32'h0E;
   localparam logic [31:0] W_NVCLR  = 32'h0F;
   localparam logic [31:0] W_RSTCTL = 32'h10;
   localparam logic [31:0] W_ONE    = 32'h11;
   localparam logic [31:0] W_CARD   = 32'h12;
   localparam logic [31:0] W_DISP   = 32'h14;
   localparam logic [31:0] W_TICK   = 32'h17;
   localparam logic [31:0] W_PROC0  = 32'h21;
   localparam logic [31:0] W_PROC1  = 32'h22;

   localparam logic [31:0] PROC1_VALUE = 32'hFF00_0000;

   typedef enum logic [2:0] {
      DISP_MUXED,
      DISP_NOMUX,
      DISP_BIT7,
      DISP_FIXED,
      DISP_ABSENT
   } disp_kind_e;

   function automatic disp_kind_e disp_kind(input logic [11:0] bt);
      case (bt)
         12'h100: return DISP_MUXED;
         12'h140: return DISP_NOMUX;
         12'h178, 12'h182: return DISP_BIT7;
         12'h190: return DISP_ABSENT;
         default: return DISP_FIXED;
      endcase
   endfunction

   function automatic logic [31:0] disp_wmask(input disp_kind_e k);
      case (k)
         DISP_MUXED, DISP_NOMUX: return 32'hFFFF_C0FF;
         DISP_BIT7:              return 32'hFFFF_FF7F;
         default:                return 32'h0000_0000;
      endcase
   endfunction

   function automatic logic [31:0] disp_reset(input disp_kind_e k);
      return (k == DISP_ABSENT) ? 32'h0 : 32'h0000_1F00;
   endfunction

   function automatic logic is_mapped(input logic [31:0] w);
      return (w <= 32'h1D) || (w >= 32'h20 && w <= 32'h27) ||
             (w >= 32'h30 && w <= 32'h34);
   endfunction

endpackage

// File: rtl/sysreg_keyed_reset.sv
module sysreg_keyed_reset
   import sysreg_pkg::*;
#(
   parameter bit PRESENT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        lock_wr_i,
   input  logic        ctl_wr_i,
   input  logic [31:0] wdata_i,
   output logic [15:0] lock_o,
   output logic [31:0] ctl_o,
   output logic        req_o
);
   localparam logic [15:0] KEY16 = UNLOCK_KEY[15:0];

   logic [15:0] lock_q;
   logic [31:0] ctl_q;
   logic        req_q;
   logic        unlocked;
   logic        accept;

   assign unlocked = (lock_q == KEY16);
   assign accept   = PRESENT && ctl_wr_i && unlocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= '0;
         ctl_q  <= '0;
         req_q  <= 1'b0;
      end else begin
         if (lock_wr_i) begin
            if (wdata_i == UNLOCK_KEY) lock_q <= KEY16;
            else                       lock_q <= {1'b0, wdata_i[14:0]};
         end
         if (accept) ctl_q <= wdata_i;
         req_q <= accept && wdata_i[8];
      end
   end

   generate
      if (PRESENT) begin : g_present
         assign ctl_o = ctl_q;
         assign req_o = req_q;
      end else begin : g_absent
         assign ctl_o = '0;
         assign req_o = 1'b0;
      end
   endgenerate

   assign lock_o = lock_q;

   p_lock_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_wr_i && wdata_i != UNLOCK_KEY) |=> !lock_q[15]);
   p_ctl_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_i && !unlocked) |=> ctl_q == $past(ctl_q));
   p_req_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> $past(ctl_wr_i && unlocked && wdata_i[8]));

endmodule

// File: rtl/sysreg_setclr.sv
module sysreg_setclr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_i,
   input  logic         clr_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_chk
      $error("sysreg_setclr: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= '0;
      else if (set_i) q_o <= q_o | data_i;
      else if (clr_i) q_o <= q_o & ~data_i;
   end

   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> (q_o & $past(data_i)) == $past(data_i));
   p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> (q_o & $past(data_i)) == '0);

endmodule

// File: rtl/sysreg_display.sv
module sysreg_display
   import sysreg_pkg::*;
#(
   parameter disp_kind_e KIND = DISP_FIXED
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_i,
   input  logic [31:0] wdata_i,
   output logic [31:0] q_o,
   output logic [1:0]  mux_o
);
   localparam logic [31:0] WMASK = disp_wmask(KIND);
   localparam logic [31:0] RVAL  = disp_reset(KIND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= RVAL;
      else if (wr_i) q_o <= (q_o & ~WMASK) | (wdata_i & WMASK);
   end

   generate
      if (KIND == DISP_MUXED) begin : g_mux
         logic [1:0] mux_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    mux_q <= 2'b00;
            else if (wr_i) mux_q <= wdata_i[1:0];
         end
         assign mux_o = mux_q;
      end else begin : g_nomux
         assign mux_o = 2'b00;
      end
   endgenerate

   // covers the kept bits of R7 and R8
   p_kept_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (q_o & ~WMASK) == ($past(q_o) & ~WMASK));

endmodule

// File: rtl/sysreg_tick.sv
module sysreg_tick #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   output logic [W-1:0] count_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count_o <= '0;
      else if (en_i) count_o <= count_o + 1'b1;
   end

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(count_o));

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
   import sysreg_pkg::*;
#(
   parameter logic [31:0] ID_WORD   = 32'h0100_0000,
   parameter logic [31:0] PROC_WORD = 32'h0000_0000,
   parameter int          ADDR_W    = 6,
   parameter int          TICK_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   input  logic              card_present_i,
   input  logic              write_prot_i,
   input  logic              tick_en_i,
   output logic [31:0]       rdata_o,
   output logic              reset_req_o,
   output logic [1:0]        disp_mux_o,
   output logic              bad_access_o
);
   localparam logic [11:0] BOARD   = ID_WORD[27:16];
   localparam disp_kind_e  DKIND   = disp_kind(BOARD);
   localparam bit          HAS_RST = (BOARD != 12'h190);
   localparam int          WP_BIT  = (BOARD == 12'h100 || BOARD == 12'h140) ? 2 : 1;

   if (ADDR_W < 6 || ADDR_W > 30) begin : g_chk_addr
      $error("sysreg_bank: ADDR_W must be 6..30");
   end
   if (TICK_W < 1 || TICK_W > 32) begin : g_chk_tick
      $error("sysreg_bank: TICK_W must be 1..32");
   end

   logic [31:0] widx;
   logic        mapped;
   logic        wr_hit;
   assign widx   = 32'(addr_i);
   assign mapped = is_mapped(widx);
   assign wr_hit = wr_en_i && mapped;

   // plain read/write words
   logic [31:0] led_q, cfg1_q, cfg2_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_q  <= '0;
         cfg1_q <= '0;
         cfg2_q <= '0;
      end else if (wr_hit) begin
         if (widx == W_LED)  led_q  <= wdata_i;
         if (widx == W_CFG1) cfg1_q <= wdata_i;
         if (widx == W_CFG2) cfg2_q <= wdata_i;
      end
   end

   logic [15:0] lock_w;
   logic [31:0] ctl_w;
   sysreg_keyed_reset #(.PRESENT(HAS_RST)) u_keyed (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock_wr_i (wr_hit && widx == W_LOCK),
      .ctl_wr_i  (wr_hit && widx == W_RSTCTL),
      .wdata_i   (wdata_i),
      .lock_o    (lock_w),
      .ctl_o     (ctl_w),
      .req_o     (reset_req_o)
   );

   logic [31:0] flags_w, nvflags_w;
   sysreg_setclr #(.W(32)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (wr_hit && widx == W_FSET),
      .clr_i  (wr_hit && widx == W_FCLR),
      .data_i (wdata_i),
      .q_o    (flags_w)
   );
   sysreg_setclr #(.W(32)) u_nvflags (
      .clk    (clk),
      .rst_n  (por_n),
      .set_i  (wr_hit && widx == W_NVSET),
      .clr_i  (wr_hit && widx == W_NVCLR),
      .data_i (wdata_i),
      .q_o    (nvflags_w)
   );

   logic [31:0] disp_w;
   sysreg_display #(.KIND(DKIND)) u_disp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_hit && widx == W_DISP),
      .wdata_i (wdata_i),
      .q_o     (disp_w),
      .mux_o   (disp_mux_o)
   );

   logic [TICK_W-1:0] tick_w;
   sysreg_tick #(.W(TICK_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (tick_en_i),
      .count_o (tick_w)
   );

   logic [31:0] card_w;
   always_comb begin
      card_w         = '0;
      card_w[0]      = card_present_i;
      card_w[WP_BIT] = write_prot_i;
   end

   logic [31:0] rd_val;
   always_comb begin
      rd_val = '0;
      case (widx)
         W_IDENT:  rd_val = ID_WORD;
         W_LED:    rd_val = led_q;
         W_LOCK:   rd_val = {16'h0, lock_w};
         W_CFG1:   rd_val = cfg1_q;
         W_CFG2:   rd_val = cfg2_q;
         W_FSET:   rd_val = flags_w;
         W_NVSET:  rd_val = nvflags_w;
         W_RSTCTL: rd_val = ctl_w;
         W_ONE:    rd_val = 32'h1;
         W_CARD:   rd_val = card_w;
         W_DISP:   rd_val = disp_w;
         W_TICK:   rd_val = 32'(tick_w);
         W_PROC0:  rd_val = PROC_WORD;
         W_PROC1:  rd_val = PROC1_VALUE;
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o      <= '0;
         bad_access_o <= 1'b0;
      end else begin
         rdata_o      <= rd_en_i ? rd_val : '0;
         bad_access_o <= (rd_en_i || wr_en_i) && !mapped;
      end
   end

   p_bad_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access_o |-> $past((rd_en_i || wr_en_i) && !is_mapped(32'(addr_i))));
   p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> rdata_o == '0);

endmodule

// File: tb/sysreg_bank_test.sv
module sysreg_bank_test;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0, por_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, tick_en = 1'b0;
   logic        card = 1'b0, wp = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;

   logic [31:0] rd  [3];
   logic        req [3];
   logic [1:0]  mux [3];
   logic        bad [3];

   localparam logic [31:0] ID_A = 32'h0100_5A01, ID_B = 32'h0178_0011, ID_C = 32'h0190_0022;
   localparam logic [31:0] PR_A = 32'h4100_0001, PR_B = 32'h4200_0002, PR_C = 32'h4300_0003;

   sysreg_bank #(.ID_WORD(ID_A), .PROC_WORD(PR_A)) uut (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .card_present_i(card), .write_prot_i(wp),
      .tick_en_i(tick_en), .rdata_o(rd[0]), .reset_req_o(req[0]),
      .disp_mux_o(mux[0]), .bad_access_o(bad[0]));
   sysreg_bank #(.ID_WORD(ID_B), .PROC_WORD(PR_B)) uut_b (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .card_present_i(card), .write_prot_i(wp),
      .tick_en_i(tick_en), .rdata_o(rd[1]), .reset_req_o(req[1]),
      .disp_mux_o(mux[1]), .bad_access_o(bad[1]));
   sysreg_bank #(.ID_WORD(ID_C), .PROC_WORD(PR_C)) uut_c (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .card_present_i(card), .write_prot_i(wp),
      .tick_en_i(tick_en), .rdata_o(rd[2]), .reset_req_o(req[2]),
      .disp_mux_o(mux[2]), .bad_access_o(bad[2]));

   int checks = 0, fails = 0;
   bit done = 0;

   // model state
   logic [31:0] id_m[3], pr_m[3];
   int          bt[3];
   logic [31:0] m_led[3], m_cfg1[3], m_cfg2[3], m_flg[3], m_nv[3], m_rst[3], m_disp[3];
   logic [15:0] m_lock[3];
   logic [1:0]  m_mux[3];
   logic [31:0] m_tick;

   task automatic chk(input string req_tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
      end
   endtask

   function automatic bit mapped(input int w);
      return (w <= 'h1D) || (w >= 'h20 && w <= 'h27) || (w >= 'h30 && w <= 'h34);
   endfunction

   function automatic string tag_of(input int w);
      case (w)
         'h00, 'h11, 'h17, 'h21, 'h22: return "R10";
         'h02, 'h0A, 'h0B: return "R13";
         'h08: return "R1";
         'h0C, 'h0D: return "R3";
         'h0E, 'h0F: return "R4";
         'h10: return "R2";
         'h12: return "R9";
         'h14: return "R7";
         default: return mapped(w) ? "R13" : "R12";
      endcase
   endfunction

   function automatic logic [31:0] exp_rd(input int k, input int w);
      case (w)
         'h00: return id_m[k];
         'h02: return m_led[k];
         'h08: return {16'h0, m_lock[k]};
         'h0A: return m_cfg1[k];
         'h0B: return m_cfg2[k];
         'h0C: return m_flg[k];
         'h0E: return m_nv[k];
         'h10: return (bt[k] == 'h190) ? 32'h0 : m_rst[k];
         'h11: return 32'h1;
         'h12: return {29'h0, (bt[k] == 'h100 || bt[k] == 'h140) ? {wp, 1'b0} : {1'b0, wp}, card};
         'h14: return m_disp[k];
         'h17: return m_tick;
         'h21: return pr_m[k];
         'h22: return 32'hFF00_0000;
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 3; k++) begin
         m_led[k] = 0; m_cfg1[k] = 0; m_cfg2[k] = 0; m_flg[k] = 0; m_rst[k] = 0;
         m_lock[k] = 0; m_mux[k] = 0;
         m_disp[k] = (bt[k] == 'h190) ? 32'h0 : 32'h0000_1F00;
      end
      m_tick = 0;
   endtask

   task automatic bus_reset();
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk) rst_n = 1'b1;
      model_reset();
      for (int k = 0; k < 3; k++) begin
         chk("R5", "reset req", {31'h0, req[k]}, 32'h0);
         chk("R5", "reset mux", {30'h0, mux[k]}, 32'h0);
         chk("R11", "reset rdata", rd[k], 32'h0);
      end
   endtask

   task automatic do_read(input int w);
      @(negedge clk);
      addr = w[5:0]; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk(tag_of(w), $sformatf("read w%02h dut%0d", w, k), rd[k], exp_rd(k, w));
         chk("R12", $sformatf("bad flag read w%02h", w), {31'h0, bad[k]}, {31'h0, !mapped(w)});
      end
   endtask

   task automatic do_write(input int w, input logic [31:0] d);
      logic [2:0] exp_req;
      exp_req = '0;
      for (int k = 0; k < 3; k++) begin
         if (mapped(w)) begin
            case (w)
               'h02: m_led[k] = d;
               'h0A: m_cfg1[k] = d;
               'h0B: m_cfg2[k] = d;
               'h0C: m_flg[k] = m_flg[k] | d;
               'h0D: m_flg[k] = m_flg[k] & ~d;
               'h0E: m_nv[k] = m_nv[k] | d;
               'h0F: m_nv[k] = m_nv[k] & ~d;
               'h08: m_lock[k] = (d == 32'h0000_A05F) ? 16'hA05F : {1'b0, d[14:0]};
               'h10: if (bt[k] != 'h190 && m_lock[k] == 16'hA05F) begin
                  m_rst[k] = d;
                  exp_req[k] = d[8];
               end
               'h14: begin
                  if (bt[k] == 'h100 || bt[k] == 'h140)
                     m_disp[k] = (m_disp[k] & 32'h3F00) | (d & ~32'h3F00);
                  else if (bt[k] == 'h178 || bt[k] == 'h182)
                     m_disp[k] = (m_disp[k] & 32'h80) | (d & ~32'h80);
                  if (bt[k] == 'h100) m_mux[k] = d[1:0];
               end
               default: ;
            endcase
         end
      end
      @(negedge clk);
      addr = w[5:0]; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk("R2", $sformatf("req after w%02h dut%0d", w, k), {31'h0, req[k]}, {31'h0, exp_req[k]});
         chk("R12", $sformatf("bad flag write w%02h", w), {31'h0, bad[k]}, {31'h0, !mapped(w)});
         chk("R7", "disp mux", {30'h0, mux[k]}, {30'h0, m_mux[k]});
      end
   endtask

   task automatic read_sweep();
      for (int w = 0; w < 64; w++) do_read(w);
      @(negedge clk);
      for (int k = 0; k < 3; k++) chk("R11", "idle rdata", rd[k], 32'h0);
   endtask

   initial begin
      id_m = '{ID_A, ID_B, ID_C};
      pr_m = '{PR_A, PR_B, PR_C};
      bt   = '{'h100, 'h178, 'h190};
      for (int k = 0; k < 3; k++) m_nv[k] = 0;
      model_reset();
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      rst_n = 1'b1;
      bus_reset();
      read_sweep();                                  // R5 R10 R12 R13 reset view

      for (int p = 0; p < 3; p++) begin              // R3 R4 R7 R8 R12 R13 sweeps
         for (int w = 0; w < 64; w++) begin
            logic [31:0] d;
            d = (p == 1) ? 32'hFFFF_FFFF : (32'h9E37_79B9 * 32'(w + 1 + p * 64)) ^ {16'h0, 10'h0, w[5:0]};
            do_write(w, d);
         end
         read_sweep();
      end

      // R1 lock key and near misses, R2 reset request, R6 absent on 0x190
      do_write('h08, 32'h0000_A05F);
      do_read('h08);
      do_write('h10, 32'h0000_0155);
      do_read('h10);
      do_write('h10, 32'h0000_0023);
      do_read('h10);
      do_write('h08, 32'h0001_A05F);
      do_read('h08);
      do_write('h10, 32'h0000_0100);
      do_read('h10);
      do_write('h08, 32'h0000_205F);
      do_read('h08);

      // R7 mux values
      do_write('h14, 32'h0000_0002);
      do_write('h14, 32'h0000_0001);
      do_read('h14);

      // R4 non-volatile flags survive bus reset, R3/R5 volatile ones do not
      do_write('h0C, 32'h0000_F0F0);
      do_write('h0E, 32'h1234_0000);
      do_write('h0F, 32'h0004_0000);
      bus_reset();
      read_sweep();

      // R9 card status combos
      for (int c = 0; c < 4; c++) begin
         card = c[0]; wp = c[1];
         do_read('h12);
      end

      // R10 tick counter
      @(negedge clk) tick_en = 1'b1;
      repeat (37) @(negedge clk);
      tick_en = 1'b0;
      m_tick = 37;
      do_read('h17);
      repeat (5) @(negedge clk);
      do_read('h17);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule